// File: doc/BRIEF.md
# Dueling LRU/Random Victim Selector

This block chooses the way to evict in a set-associative cache. It settles at run time whether least-recently-used or pseudo-random replacement works better for the current workload. A small sample of sets, called leader sets, is chosen by a fixed pattern in the set index. On each leader set the main tag store always uses random replacement. A compact shadow tag store models what an LRU-managed copy of the same set would hold. Each access to a leader set compares the two outcomes and moves one global saturating counter up or down. Every other set follows whichever policy the counter currently favours.

Each cycle the cache presents the access set index and tag, the valid bits of that set's ways in the main store, and the main store's hit result and hit way. The block returns at once the way to fill when the access misses, and the policy that non-leader sets are using. The block updates its recency and pseudo-random state on the following clock edge.

Top module: `hrs_selector`

## Requirements
- R1: After reset the policy counter holds its midpoint, 2^(CTR_W-1) (512 for the default 10 bits). So `use_random` reads 1.
- R2: When any way of the accessed set is marked invalid in `way_valid`, `victim_way` is the lowest-numbered invalid way, whatever policy is in force.
- R3: A set is a leader set when its index bits [LEADER_SEL_W-1:0] equal LEADER_PAT (by default bits [4:0] equal 3, which gives 8 leaders among 256 sets). On a leader set with all ways valid, `victim_way` is always the random way.
- R4: On a non-leader set with all ways valid, `victim_way` is the random way while `use_random` is 1.
- R5: On a non-leader set with all ways valid, `victim_way` is the least recently touched way while `use_random` is 0. A way is touched when it is the hit way (`main_hit`=1) or the returned victim (`main_hit`=0) of an access with `acc_valid`=1. After reset the recency order of every set, from most to least recent, is way 0, way 1, and so on, so way WAYS-1 is the first LRU victim.
- R6: The random way is bits [WAY_W-1:0] of a 16-bit register. The register resets to 16'hACE1 and steps to {s[14:0], s[15]^s[13]^s[12]^s[10]} only on an access with `acc_valid`=1 and `main_hit`=0.
- R7: On a leader-set access, the counter increments when the main store hits and the shadow LRU store misses. It decrements when the main store misses and the shadow store hits. Otherwise it is unchanged. Accesses to non-leader sets never change it.
- R8: The counter saturates at 0 and at 2^CTR_W-1 and never wraps.
- R9: The shadow store keeps WAYS tags for each leader set. It hits when the access tag equals one of that set's valid tags. On a miss it writes the tag into the lowest invalid entry, or into its least recently used entry when all are valid. Its recency follows the same rules as R5.
- R10: `use_random` equals the most significant bit of the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_set | input | SET_W (8) | Set index of the access |
| acc_tag | input | TAG_W (20) | Tag of the access |
| main_hit | input | 1 | Main tag store hit for this access |
| main_hit_way | input | WAY_W (2) | Way that hit in the main store |
| way_valid | input | WAYS (4) | Valid bits of the accessed set in the main store |
| victim_way | output | WAY_W (2) | Way to fill on a miss |
| use_random | output | 1 | Policy applied to non-leader sets (1 = random) |

## Verification
The hardest state to reach is the counter sitting exactly at a rail or on either side of its most significant bit boundary. That state is visible only through `use_random`, and it moves only on leader-set accesses where the two stores disagree. The bench drives a leader set with a stream of never-repeated tags while holding the main store as hitting, which forces a shadow miss on every access and pushes the counter past the top. A single tag is then repeated with the main store missing, so the shadow store hits every time. A counted run of such accesses then shows the MSB flip on the exact access that R8 predicts, at both ends. Mixed random phases across leader and follower sets, each biased toward one outcome, exercise both follower policies against a bench model of recency, the pseudo-random sequence and the shadow tags.

// File: rtl/hrs_pkg.sv
`timescale 1ns/1ps
package hrs_pkg;
   localparam int unsigned  LFSR_W    = 16;
   localparam logic [15:0]  LFSR_SEED = 16'hACE1;

   function automatic logic [15:0] lfsr_next(input logic [15:0] s);
      return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
   endfunction
endpackage

// File: rtl/hrs_lfsr.sv
`timescale 1ns/1ps
module hrs_lfsr #(
   parameter int unsigned OUT_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step,
   output logic [OUT_W-1:0] pick
);
   import hrs_pkg::*;

   logic [LFSR_W-1:0] state_q;

   generate
      if (OUT_W > LFSR_W) begin : g_bad_out
         $error("hrs_lfsr: OUT_W wider than state");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    state_q <= LFSR_SEED;
      else if (step) state_q <= lfsr_next(state_q);
   end

   assign pick = state_q[OUT_W-1:0];

   AST_LFSR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !step |=> $stable(state_q)); // R6
   AST_LFSR_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
      state_q != '0); // R6
endmodule

// File: rtl/hrs_sat_ctr.sv
`timescale 1ns/1ps
module hrs_sat_ctr #(
   parameter int unsigned CTR_W = 10
) (
   input  logic clk,
   input  logic rst_n,
   input  logic inc,
   input  logic dec,
   output logic msb
);
   localparam logic [CTR_W-1:0] TOP = '1;
   localparam logic [CTR_W-1:0] MID = {1'b1, {(CTR_W-1){1'b0}}};

   logic [CTR_W-1:0] cnt_q;

   generate
      if (CTR_W < 2) begin : g_bad_w
         $error("hrs_sat_ctr: CTR_W must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                               cnt_q <= MID;
      else if (inc && !dec && cnt_q != TOP)     cnt_q <= cnt_q + 1'b1;
      else if (dec && !inc && cnt_q != '0)      cnt_q <= cnt_q - 1'b1;
   end

   assign msb = cnt_q[CTR_W-1];

   AST_CTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !(inc || dec) |=> $stable(cnt_q)); // R7
   AST_CTR_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q == TOP && inc) |=> cnt_q == TOP); // R8
   AST_CTR_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q == '0 && dec) |=> cnt_q == '0); // R8
endmodule

// File: rtl/hrs_age_lru.sv
`timescale 1ns/1ps
module hrs_age_lru #(
   parameter int unsigned ENTRIES = 256,
   parameter int unsigned WAYS    = 4,
   localparam int unsigned IDX_W  = $clog2(ENTRIES),
   localparam int unsigned WAY_W  = $clog2(WAYS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] idx,
   input  logic             touch_en,
   input  logic [WAY_W-1:0] touch_way,
   output logic [WAY_W-1:0] lru_way
);
   localparam logic [WAY_W-1:0] OLDEST = WAY_W'(WAYS - 1);

   logic [WAY_W-1:0] age_q [ENTRIES][WAYS];
   logic [WAY_W-1:0] ref_age;
   logic [WAYS-1:0]  oldest;

   assign ref_age = age_q[idx][touch_way];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int e = 0; e < ENTRIES; e++)
            for (int w = 0; w < WAYS; w++)
               age_q[e][w] <= WAY_W'(w);
      end else if (touch_en) begin
         for (int w = 0; w < WAYS; w++) begin
            if (WAY_W'(w) == touch_way)        age_q[idx][w] <= '0;
            else if (age_q[idx][w] < ref_age)  age_q[idx][w] <= age_q[idx][w] + 1'b1;
         end
      end
   end

   for (genvar w = 0; w < WAYS; w++) begin : g_old
      assign oldest[w] = (age_q[idx][w] == OLDEST);
   end

   always_comb begin
      lru_way = '0;
      for (int w = 0; w < WAYS; w++)
         if (oldest[w]) lru_way = WAY_W'(w);
   end

   AST_AGE_ONE_OLDEST: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(oldest) == 1); // R5
endmodule

// File: rtl/hrs_shadow_lru.sv
`timescale 1ns/1ps
module hrs_shadow_lru #(
   parameter int unsigned LEADERS = 8,
   parameter int unsigned WAYS    = 4,
   parameter int unsigned TAG_W   = 20,
   localparam int unsigned SLOT_W = $clog2(LEADERS),
   localparam int unsigned WAY_W  = $clog2(WAYS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              lookup,
   input  logic [SLOT_W-1:0] slot,
   input  logic [TAG_W-1:0]  tag,
   output logic              hit
);
   logic [TAG_W-1:0] tag_q [LEADERS][WAYS];
   logic [WAYS-1:0]  vld_q [LEADERS];
   logic [WAYS-1:0]  match;
   logic [WAY_W-1:0] hit_way, inv_way, lru_way, fill_way, touch_way;
   logic             any_inv;

   for (genvar w = 0; w < WAYS; w++) begin : g_cmp
      assign match[w] = vld_q[slot][w] && (tag_q[slot][w] == tag);
   end

   always_comb begin
      hit_way = '0;
      any_inv = 1'b0;
      inv_way = '0;
      for (int w = 0; w < WAYS; w++)
         if (match[w]) hit_way = WAY_W'(w);
      for (int w = WAYS - 1; w >= 0; w--)
         if (!vld_q[slot][w]) begin
            any_inv = 1'b1;
            inv_way = WAY_W'(w);
         end
   end

   assign hit       = |match;
   assign fill_way  = any_inv ? inv_way : lru_way;
   assign touch_way = hit ? hit_way : fill_way;

   hrs_age_lru #(.ENTRIES(LEADERS), .WAYS(WAYS)) u_age (
      .clk      (clk),
      .rst_n    (rst_n),
      .idx      (slot),
      .touch_en (lookup),
      .touch_way(touch_way),
      .lru_way  (lru_way)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int e = 0; e < LEADERS; e++) begin
            vld_q[e] <= '0;
            for (int w = 0; w < WAYS; w++) tag_q[e][w] <= '0;
         end
      end else if (lookup && !hit) begin
         tag_q[slot][fill_way] <= tag;
         vld_q[slot][fill_way] <= 1'b1;
      end
   end

   AST_SHADOW_UNIQUE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(match)); // R9
endmodule

// File: rtl/hrs_selector.sv
`timescale 1ns/1ps
module hrs_selector #(
   parameter int unsigned SETS         = 256,
   parameter int unsigned WAYS         = 4,
   parameter int unsigned TAG_W        = 20,
   parameter int unsigned LEADER_SEL_W = 5,
   parameter int unsigned LEADER_PAT   = 3,
   parameter int unsigned CTR_W        = 10,
   localparam int unsigned SET_W       = $clog2(SETS),
   localparam int unsigned WAY_W       = $clog2(WAYS),
   localparam int unsigned LEADERS     = SETS >> LEADER_SEL_W,
   localparam int unsigned SLOT_W      = $clog2(LEADERS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             acc_valid,
   input  logic [SET_W-1:0] acc_set,
   input  logic [TAG_W-1:0] acc_tag,
   input  logic             main_hit,
   input  logic [WAY_W-1:0] main_hit_way,
   input  logic [WAYS-1:0]  way_valid,
   output logic [WAY_W-1:0] victim_way,
   output logic             use_random
);
   logic              is_leader, any_inv, aux_hit, lookup;
   logic [SLOT_W-1:0] slot;
   logic [WAY_W-1:0]  first_inv, rnd_way, lru_way, touch_way;

   generate
      if (WAYS < 2 || (WAYS & (WAYS - 1)) != 0) begin : g_bad_ways
         $error("hrs_selector: WAYS must be a power of two of at least 2");
      end
      if ((SETS & (SETS - 1)) != 0 || LEADER_SEL_W + 1 > SET_W) begin : g_bad_sets
         $error("hrs_selector: SETS must be a power of two with at least two leaders");
      end
      if (LEADER_PAT >= (1 << LEADER_SEL_W)) begin : g_bad_pat
         $error("hrs_selector: LEADER_PAT does not fit LEADER_SEL_W");
      end
   endgenerate

   assign is_leader = (acc_set[LEADER_SEL_W-1:0] == LEADER_SEL_W'(LEADER_PAT));
   assign slot      = acc_set[SET_W-1:LEADER_SEL_W];
   assign lookup    = acc_valid && is_leader;

   always_comb begin
      any_inv   = 1'b0;
      first_inv = '0;
      for (int w = WAYS - 1; w >= 0; w--)
         if (!way_valid[w]) begin
            any_inv   = 1'b1;
            first_inv = WAY_W'(w);
         end
   end

   assign victim_way = any_inv ? first_inv
                     : ((is_leader || use_random) ? rnd_way : lru_way);
   assign touch_way  = main_hit ? main_hit_way : victim_way;

   hrs_lfsr #(.OUT_W(WAY_W)) u_rand (
      .clk  (clk),
      .rst_n(rst_n),
      .step (acc_valid && !main_hit),
      .pick (rnd_way)
   );

   hrs_age_lru #(.ENTRIES(SETS), .WAYS(WAYS)) u_main_age (
      .clk      (clk),
      .rst_n    (rst_n),
      .idx      (acc_set),
      .touch_en (acc_valid),
      .touch_way(touch_way),
      .lru_way  (lru_way)
   );

   hrs_shadow_lru #(.LEADERS(LEADERS), .WAYS(WAYS), .TAG_W(TAG_W)) u_shadow (
      .clk   (clk),
      .rst_n (rst_n),
      .lookup(lookup),
      .slot  (slot),
      .tag   (acc_tag),
      .hit   (aux_hit)
   );

   hrs_sat_ctr #(.CTR_W(CTR_W)) u_duel (
      .clk  (clk),
      .rst_n(rst_n),
      .inc  (lookup && main_hit && !aux_hit),
      .dec  (lookup && !main_hit && aux_hit),
      .msb  (use_random)
   );

   AST_INVALID_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && !(&way_valid)) |-> !way_valid[victim_way]); // R2
   AST_LEADER_RANDOM: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && is_leader && (&way_valid)) |-> victim_way == rnd_way); // R3
   AST_POLICY_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(use_random) |-> $past(lookup)); // R7
endmodule

// File: tb/hrs_selector_test.sv
`timescale 1ns/1ps
module hrs_selector_test;
   localparam int SETS = 256, WAYS = 4, TAG_W = 20;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             acc_valid = 1'b0;
   logic [7:0]       acc_set = '0;
   logic [TAG_W-1:0] acc_tag = '0;
   logic             main_hit = 1'b0;
   logic [1:0]       main_hit_way = '0;
   logic [3:0]       way_valid = '0;
   logic [1:0]       victim_way;
   logic             use_random;

   hrs_selector uut (
      .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_set(acc_set),
      .acc_tag(acc_tag), .main_hit(main_hit), .main_hit_way(main_hit_way),
      .way_valid(way_valid), .victim_way(victim_way), .use_random(use_random)
   );

   always #5 clk = ~clk;

   int          n_checks = 0, n_err = 0;
   bit          done = 0;
   int          m_age [SETS][WAYS];
   int          a_age [8][WAYS];
   int          a_tag [8][WAYS];
   bit          a_vld [8][WAYS];
   int          ctr = 512;
   logic [15:0] lfsr = 16'hACE1;
   int          set_pool [6] = '{0, 3, 35, 1, 99, 131};

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic bit is_leader(input int s);
      return (s & 31) == 3;
   endfunction

   function automatic int m_lru(input int s);
      for (int w = 0; w < WAYS; w++) if (m_age[s][w] == WAYS - 1) return w;
      return 0;
   endfunction

   function automatic int a_lru(input int k);
      for (int w = 0; w < WAYS; w++) if (a_age[k][w] == WAYS - 1) return w;
      return 0;
   endfunction

   task automatic touch_m(input int s, input int w);
      int r = m_age[s][w];
      for (int i = 0; i < WAYS; i++) if (m_age[s][i] < r) m_age[s][i]++;
      m_age[s][w] = 0;
   endtask

   task automatic touch_a(input int k, input int w);
      int r = a_age[k][w];
      for (int i = 0; i < WAYS; i++) if (a_age[k][i] < r) a_age[k][i]++;
      a_age[k][w] = 0;
   endtask

   task automatic do_acc(input int s, input int t, input bit h, input int hw, input logic [3:0] vv);
      int    exp;
      string lab;
      @(negedge clk);
      acc_valid = 1'b1; acc_set = 8'(s); acc_tag = TAG_W'(t);
      main_hit = h; main_hit_way = 2'(hw); way_valid = vv;
      #1;
      exp = -1;
      for (int w = WAYS - 1; w >= 0; w--) if (!vv[w]) exp = w;
      if (exp >= 0)                           lab = "R2";
      else if (is_leader(s)) begin exp = int'(lfsr[1:0]); lab = "R3"; end
      else if (ctr >= 512)   begin exp = int'(lfsr[1:0]); lab = "R4"; end
      else                   begin exp = m_lru(s);        lab = "R5"; end
      check(victim_way == 2'(exp), lab, int'(victim_way), exp);
      check(use_random == (ctr >= 512), "R10", int'(use_random), int'(ctr >= 512));
      @(posedge clk);
      if (is_leader(s)) begin
         int k = s >> 5, aw = -1;
         bit ah = 0;
         for (int w = 0; w < WAYS; w++) if (a_vld[k][w] && a_tag[k][w] == t) begin ah = 1; aw = w; end
         if (!ah) begin
            for (int w = WAYS - 1; w >= 0; w--) if (!a_vld[k][w]) aw = w;
            if (aw < 0) aw = a_lru(k);
            a_tag[k][aw] = t; a_vld[k][aw] = 1;
         end
         touch_a(k, aw);
         if (h && !ah && ctr < 1023) ctr++;      // R7
         else if (!h && ah && ctr > 0) ctr--;    // R7
      end
      touch_m(s, h ? hw : exp);
      if (!h) lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      #1 acc_valid = 1'b0;
   endtask

   task automatic check_policy(input bit exp, input string req);
      @(negedge clk); #1;
      check(use_random == exp, req, int'(use_random), int'(exp));
   endtask

   initial begin
      for (int s = 0; s < SETS; s++) for (int w = 0; w < WAYS; w++) m_age[s][w] = w;
      for (int k = 0; k < 8; k++) for (int w = 0; w < WAYS; w++) begin
         a_age[k][w] = w; a_tag[k][w] = 0; a_vld[k][w] = 0;
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1: reset state, no access presented
      @(negedge clk);
      acc_set = 8'd0; way_valid = 4'hF; #1;
      check(use_random == 1'b1, "R1", int'(use_random), 1);
      check(victim_way == 2'd1, "R6", int'(victim_way), 1);
      // R2: every valid pattern on a follower and a leader set
      for (int p = 0; p < 15; p++) begin
         do_acc(0, 1, 1'b1, 0, 4'(p));
         do_acc(3, 9, 1'b0, 0, 4'(p));
      end
      // Mixed phases: misses dominate (drives toward LRU), then hits dominate
      for (int i = 0; i < 2400; i++) begin
         bit h = (i < 1200) ? ($urandom() % 5 == 0) : ($urandom() % 5 != 0);
         logic [3:0] vv = ($urandom() % 10 == 0) ? 4'($urandom()) : 4'hF;
         do_acc(set_pool[$urandom() % 6], int'($urandom() % 6), h, int'($urandom() % 4), vv);
      end
      // R8: push to the top rail with a shadow miss on every leader access
      for (int i = 0; i < 1100; i++) do_acc(67, 5000 + i, 1'b1, 0, 4'hF);
      check_policy(1'b1, "R8");
      do_acc(67, 7777, 1'b0, 0, 4'hF);   // shadow fill, counter unchanged
      for (int i = 0; i < 511; i++) do_acc(67, 7777, 1'b0, 0, 4'hF);
      check_policy(1'b1, "R8");
      do_acc(67, 7777, 1'b0, 0, 4'hF);
      check_policy(1'b0, "R8");
      // R5: untouched follower set under LRU; reset order makes way 3 oldest
      do_acc(200, 1, 1'b1, 3, 4'hF);
      do_acc(200, 1, 1'b1, 2, 4'hF);
      do_acc(200, 1, 1'b0, 0, 4'hF);
      do_acc(200, 1, 1'b0, 0, 4'hF);
      do_acc(200, 1, 1'b1, 1, 4'hF);
      do_acc(200, 1, 1'b0, 0, 4'hF);
      // R7: follower hits and misses leave the policy alone
      for (int i = 0; i < 20; i++) do_acc(201, i, i[0], 0, 4'hF);
      check_policy(1'b0, "R7");
      // R8: bottom rail
      for (int i = 0; i < 1100; i++) do_acc(67, 7777, 1'b0, 0, 4'hF);
      for (int i = 0; i < 511; i++) do_acc(67, 90000 + i, 1'b1, 0, 4'hF);
      check_policy(1'b0, "R8");
      do_acc(67, 99999, 1'b1, 0, 4'hF);
      check_policy(1'b1, "R8");
      if (!done) begin
         done = 1;
         $display("Result: errors=%0d of %0d checks", n_err, n_checks);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1;
         n_checks++; n_err++;
         $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
         $display("Result: errors=%0d of %0d checks", n_err, n_checks);
         $finish;
      end
   end
endmodule